// File: doc/BRIEF.md
# Dual-Path SPI Clock Divider

This block derives an SPI serial clock from a faster source clock. Two divider laws are available behind a single select bit. The power-of-two law divides the source by 2^(E+2) for a 3-bit exponent E. The linear law divides by 2*(L+1) for an 8-bit count L. Internally, both laws reduce to one half-period length in source cycles. A single counter measures that length, and the output toggles each time the count completes, so the duty cycle is 50% for every setting.

A serial shifter uses the block by holding `en` low while it sets up a transfer. During that time the clock rests at the idle level chosen by `cpol`. The shifter then raises `en`, and the clock starts at a known phase. The one-cycle `edge_tick` pulse marks each cycle in which `sclk` has just changed, so the shifter can sample or launch data without its own edge detector. Divider or path changes made while running are held back until the current full period ends, so the output never carries a shortened pulse.

Top module: `spi_sclk_divider`

## Requirements
- R1: With `path_sel` = 0, each half of `sclk` lasts 2^(`pow_exp`+1) source cycles, for a full period of 2^(`pow_exp`+2) cycles; `pow_exp` is 3 bits wide, giving half-periods of 2 to 256 cycles.
- R2: With `path_sel` = 1, each half of `sclk` lasts `lin_div`+1 source cycles, for a full period of 2*(`lin_div`+1) cycles; `lin_div` is 8 bits wide, so 0 gives a half-period of 1 cycle and 255 gives 256 cycles.
- R3: `path_sel` picks the law: 1 selects the linear law (R2) and 0 selects the power-of-two law (R1), whatever the other field holds.
- R4: The high and low halves of every `sclk` period have equal length (50% duty).
- R5: While `en` is low, the counters are cleared and, from the cycle after `en` is sampled low, `sclk` equals `cpol`; a stop in the middle of a period returns `sclk` to idle at once.
- R6: After `en` is sampled high at rising edge k (with `en` low before), `sclk` stays idle through edge k+H-2 and first leaves the idle level at edge k+H-1, where H is the active half-period length.
- R7: A change of `pow_exp`, `lin_div` or `path_sel` while `en` is high takes effect only at the end of the current full period (the edge at which `sclk` returns to idle); the halves before that keep the old length.
- R8: `edge_tick` is high for exactly those cycles in which `sclk` differs from its value in the previous cycle.
- R9: Under reset, `sclk` and `edge_tick` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces the idle level and clears the counters |
| path_sel | input | 1 | Divider law select: 0 power-of-two, 1 linear |
| pow_exp | input | 3 | Exponent E for the power-of-two law |
| lin_div | input | 8 | Count L for the linear law |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock output |
| edge_tick | output | 1 | One-cycle pulse in each cycle right after `sclk` changed |

## Verification
Random settings of path, exponent, count and idle level are drawn. Each run measures the first half-period and then two more half-periods. The first interval separates a correct start-up latency from an off-by-one count. The comparison between the later halves exposes duty errors and any swap of the two laws. Directed cases cover the extremes of both fields (half-periods of 1, 2 and 256 cycles), a switch of law in the middle of a period (old length until the period ends, new length after), and a disable in the middle of a half-period, which must return the clock to idle at once and restart cleanly.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  typedef enum logic {
    PATH_POW2 = 1'b0,
    PATH_LIN  = 1'b1
  } path_e;

  // Half-period minus one, in source cycles, for the power-of-two law:
  // full period 2^(e+2), so each half is 2^(e+1).
  function automatic int unsigned pow2_half_m1(input int unsigned e);
    return (32'd1 << (e + 1)) - 32'd1;
  endfunction

  // Half-period minus one for the linear law: full period 2*(n+1).
  function automatic int unsigned lin_half_m1(input int unsigned n);
    return n;
  endfunction

  // Largest half-period (cycles) reachable by each law for a field width.
  function automatic int unsigned pow2_max_half(input int unsigned w);
    return 32'd1 << ((32'd1 << w));
  endfunction

  function automatic int unsigned lin_max_half(input int unsigned w);
    return 32'd1 << w;
  endfunction

endpackage

// File: rtl/sclk_div_law.sv
module sclk_div_law
  import sclk_div_pkg::*;
#(
  parameter int POW_W = 3,
  parameter int LIN_W = 8,
  parameter int HM_W  = 8
) (
  input  logic             path_sel,
  input  logic [POW_W-1:0] pow_exp,
  input  logic [LIN_W-1:0] lin_div,
  output logic [HM_W-1:0]  half_m1
);

  logic [HM_W-1:0] pow_m1;
  logic [HM_W-1:0] lin_m1;
  path_e           path;

  assign path   = path_e'(path_sel);
  assign pow_m1 = HM_W'(pow2_half_m1(32'(pow_exp)));
  assign lin_m1 = HM_W'(lin_half_m1(32'(lin_div)));

  always_comb begin
    unique case (path)
      PATH_LIN:  half_m1 = lin_m1;
      default:   half_m1 = pow_m1;
    endcase
  end

endmodule

// File: rtl/sclk_div_shadow.sv
module sclk_div_shadow #(
  parameter int HM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            boundary,
  input  logic [HM_W-1:0] half_m1_live,
  output logic [HM_W-1:0] half_m1_act
);

  logic load;

  assign load = !en || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_m1_act <= '0;
    end else if (load) begin
      half_m1_act <= half_m1_live;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$stable(half_m1_act)) |-> $past(boundary));

endmodule

// File: rtl/sclk_div_counter.sv
module sclk_div_counter #(
  parameter int HM_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cpol,
  input  logic [HM_W-1:0] half_m1,
  output logic            sclk,
  output logic            edge_tick,
  output logic            half_done,
  output logic            boundary
);

  logic [HM_W-1:0] cnt_q;
  logic            phase_q;
  logic            sclk_q;
  logic            tick_q;
  logic            sclk_n;

  assign half_done = en && (cnt_q == half_m1);
  assign boundary  = half_done && phase_q;

  always_comb begin
    if (!en)            sclk_n = cpol;
    else if (half_done) sclk_n = phase_q ? cpol : ~sclk_q;
    else                sclk_n = sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      sclk_q  <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      if (!en) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (half_done) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
      sclk_q <= sclk_n;
      tick_q <= sclk_n ^ sclk_q;
    end
  end

  assign sclk      = sclk_q;
  assign edge_tick = tick_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_m1);

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sclk == $past(cpol)));

  // R6
  no_early_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (sclk != $past(sclk))) |-> $past(half_done));

  // R8
  tick_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_tick == (sclk != $past(sclk)));

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int POW_W = 3,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             path_sel,
  input  logic [POW_W-1:0] pow_exp,
  input  logic [LIN_W-1:0] lin_div,
  input  logic             cpol,
  output logic             sclk,
  output logic             edge_tick
);

  localparam int unsigned POW_MAX = pow2_max_half(POW_W);
  localparam int unsigned LIN_MAX = lin_max_half(LIN_W);
  localparam int unsigned MAX_HALF = (POW_MAX > LIN_MAX) ? POW_MAX : LIN_MAX;
  localparam int HM_W = (MAX_HALF > 2) ? $clog2(MAX_HALF) : 1;

  logic [HM_W-1:0] half_m1_live;
  logic [HM_W-1:0] half_m1_act;
  logic            half_done;
  logic            boundary;

  sclk_div_law #(
    .POW_W(POW_W),
    .LIN_W(LIN_W),
    .HM_W (HM_W)
  ) u_law (
    .path_sel(path_sel),
    .pow_exp (pow_exp),
    .lin_div (lin_div),
    .half_m1 (half_m1_live)
  );

  sclk_div_shadow #(
    .HM_W(HM_W)
  ) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .boundary    (boundary),
    .half_m1_live(half_m1_live),
    .half_m1_act (half_m1_act)
  );

  sclk_div_counter #(
    .HM_W(HM_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .cpol     (cpol),
    .half_m1  (half_m1_act),
    .sclk     (sclk),
    .edge_tick(edge_tick),
    .half_done(half_done),
    .boundary (boundary)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!sclk && !edge_tick));

endmodule

// File: tb/tb_spi_sclk_divider.sv
`timescale 1ns/1ps
module tb_spi_sclk_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       path_sel = 1'b0;
  logic [2:0] pow_exp = '0;
  logic [7:0] lin_div = '0;
  logic       cpol = 1'b0;
  logic       sclk;
  logic       edge_tick;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spi_sclk_divider dut (
    .clk(clk), .rst_n(rst_n), .en(en), .path_sel(path_sel),
    .pow_exp(pow_exp), .lin_div(lin_div), .cpol(cpol),
    .sclk(sclk), .edge_tick(edge_tick)
  );

  function automatic int exp_half(input bit p, input int e, input int n);
    if (p) return n + 1;
    return 2 ** (e + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Counts samples (one per cycle) until sclk changes; limit guards a stall.
  task automatic next_toggle(output int n);
    int c = 0;
    logic prev = sclk;
    do begin
      @(negedge clk);
      c++;
    end while (sclk == prev && c < 1000);
    n = c;
  endtask

  task automatic run_case(input bit p, input int e, input int n, input bit pol, input string req);
    int h = exp_half(p, e, n);
    int t;
    en = 1'b0; path_sel = p; pow_exp = 3'(e); lin_div = 8'(n); cpol = pol;
    @(negedge clk); @(negedge clk);
    chk(sclk == pol, "R5 idle level", int'(sclk), int'(pol));
    en = 1'b1;
    next_toggle(t);
    chk(t == h, "R6 first edge", t, h);
    chk(sclk == !pol && edge_tick, "R8 tick at first edge", int'(edge_tick), 1);
    next_toggle(t);
    chk(t == h, req, t, h);
    next_toggle(t);
    chk(t == h, "R4 duty", t, h);
    chk(sclk == !pol, "R4 level", int'(sclk), int'(!pol));
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed_v;
    int t;
    seed_v = $urandom(1234);
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R9 reset sclk", int'(sclk), 0);
    chk(edge_tick == 1'b0, "R9 reset tick", int'(edge_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed extremes
    run_case(1'b0, 0, 0, 1'b0, "R1 exp 0");
    run_case(1'b0, 7, 0, 1'b1, "R1 exp 7");
    run_case(1'b1, 0, 0, 1'b0, "R2 count 0");
    run_case(1'b1, 0, 255, 1'b1, "R2 count 255");
    run_case(1'b1, 7, 5, 1'b0, "R3 linear ignores exp");
    run_case(1'b0, 2, 200, 1'b1, "R3 pow2 ignores count");

    // R7: change law mid-period
    en = 1'b0; path_sel = 1'b0; pow_exp = 3'd1; cpol = 1'b0;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    next_toggle(t);
    chk(t == 4, "R7 first half old", t, 4);
    path_sel = 1'b1; lin_div = 8'd2;
    next_toggle(t);
    chk(t == 4, "R7 second half old", t, 4);
    next_toggle(t);
    chk(t == 3, "R7 new law after period", t, 3);
    next_toggle(t);
    chk(t == 3, "R7 new law kept", t, 3);

    // R5: disable mid-half, then clean restart
    en = 1'b0; path_sel = 1'b1; lin_div = 8'd9; cpol = 1'b1;
    @(negedge clk); @(negedge clk);
    en = 1'b1;
    next_toggle(t);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b1, "R5 stop mid-half", int'(sclk), 1);
    en = 1'b1;
    next_toggle(t);
    chk(t == 10, "R5 restart from cleared count", t, 10);
    en = 1'b0;
    @(negedge clk);

    // random mix
    for (int i = 0; i < 25; i++) begin
      bit p = 1'($urandom % 2);
      int e = int'($urandom % 8);
      int n = int'($urandom % 256);
      bit pol = 1'($urandom % 2);
      run_case(p, e, n, pol, p ? "R2 random" : "R1 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule